// File: doc/BRIEF.md
# Programmable Divide-by-N Pulse Divider

This block divides an input clock by an integer ratio N chosen on an 8-bit input. Two 4-bit down-counting stages are chained. The low stage's active-low carry lets the high stage step once each time the low nibble passes through zero. When the whole chain sits at zero, the block emits a one-cycle tick and reloads the chain. The chain is reloaded so that exactly N input cycles make up one output period. The result is one tick every N input clocks, which can serve as a clock enable or as a divided strobe for downstream logic.

The ratio is read only when the chain reloads, so a value changed mid-period takes effect at the next period boundary. A ratio of zero has no meaning. If the chain reaches its terminal state while the ratio is zero, it parks at zero, emits no ticks and raises a flag. It stays parked until a nonzero ratio appears.

Top module: `prog_freq_divider`

## Requirements
- R1: While `rst_i` is high (synchronous, active high), both outputs are low. In the first cycle after reset is released, `tick_o` is high if `ratio_i` is nonzero.
- R2: For a constant ratio N in 1..255, `tick_o` is high for exactly one cycle in every N consecutive cycles. Successive ticks are exactly N cycles apart.
- R3: With N = 1, `tick_o` is high on every cycle.
- R4: With all ratio bits set (N = 255), ticks are 255 cycles apart.
- R5: `ratio_i` is sampled only in a cycle where `tick_o` is high, or where the block is parked. A change at any other point does not alter the length of the period in progress.
- R6: If the chain is at its terminal state and `ratio_i` is 0, `tick_o` stays low, `zero_ratio_o` goes high and the count holds. When a nonzero ratio then appears, `tick_o` rises in that same cycle and the next period has the new length.
- R7: The low stage (bits 3:0 of the ratio) carries into the high stage (bits 7:4) once per pass of the low stage through zero. Ratios that cross nibble boundaries (16, 17, 32, 200) give the correct period.
- R8: `tick_o` and `zero_ratio_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Synchronous active-high reset; clears the chain |
| ratio_i | input | 8 | Divide ratio N in binary (0 is illegal) |
| tick_o | output | 1 | One-cycle pulse, once per N input cycles |
| zero_ratio_o | output | 1 | High while the chain is parked because N is 0 |

## Verification
The bench aims at the ends of the ratio range. With N = 1, an off-by-one reload would leave gaps between ticks. With N = 255, a design that wraps wrongly would stretch or shorten the period. Ratios of 16, 17 and 32 exercise the borrow between nibbles, where a misrouted carry shifts the period by 16 or more. Ratio changes in mid-period and a park-then-resume at N = 0 expose a design that reloads early or that decrements past zero into 255 instead of holding.

// File: rtl/divn_pkg.sv
package divn_pkg;
   localparam int DEF_NIB_W  = 4;
   localparam int DEF_STAGES = 2;
endpackage

// File: rtl/divn_stage.sv
module divn_stage #(
   parameter int W = 4
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic         cin_n_i,
   input  logic         load_i,
   input  logic [W-1:0] preset_i,
   output logic [W-1:0] q_o,
   output logic         cout_n_o,
   output logic         zero_o
);
   logic [W-1:0] q_r;

   always_ff @(posedge clk_i) begin
      if (rst_i)         q_r <= '0;
      else if (load_i)   q_r <= preset_i;
      else if (!cin_n_i) q_r <= q_r - 1'b1;
   end

   assign q_o      = q_r;
   assign zero_o   = (q_r == '0);
   assign cout_n_o = !(zero_o && !cin_n_i);
endmodule

// File: rtl/divn_reload.sv
module divn_reload #(
   parameter int RW = 8
) (
   input  logic [RW-1:0] ratio_i,
   output logic [RW-1:0] reload_o,
   output logic          illegal_o
);
   always_comb begin
      illegal_o = (ratio_i == '0);
      reload_o  = ratio_i - 1'b1;
   end
endmodule

// File: rtl/prog_freq_divider.sv
module prog_freq_divider #(
   parameter int NIB_W  = divn_pkg::DEF_NIB_W,
   parameter int STAGES = divn_pkg::DEF_STAGES,
   localparam int RATIO_W = NIB_W * STAGES
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic [RATIO_W-1:0] ratio_i,
   output logic               tick_o,
   output logic               zero_ratio_o
);
   if (NIB_W < 1) begin : g_bad_nib
      $error("NIB_W must be at least 1");
   end
   if (STAGES < 1) begin : g_bad_stages
      $error("STAGES must be at least 1");
   end

   logic [RATIO_W-1:0] reload;
   logic               illegal;
   logic [STAGES:0]    carry_n;
   logic [STAGES-1:0]  zero_s;
   logic [RATIO_W-1:0] count;
   logic               terminal, load, park;

   divn_reload #(.RW(RATIO_W)) u_reload (
      .ratio_i  (ratio_i),
      .reload_o (reload),
      .illegal_o(illegal)
   );

   assign carry_n[0] = park;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      divn_stage #(.W(NIB_W)) u_stage (
         .clk_i   (clk_i),
         .rst_i   (rst_i),
         .cin_n_i (carry_n[s]),
         .load_i  (load),
         .preset_i(reload[s*NIB_W +: NIB_W]),
         .q_o     (count[s*NIB_W +: NIB_W]),
         .cout_n_o(carry_n[s+1]),
         .zero_o  (zero_s[s])
      );
   end

   assign terminal     = &zero_s;
   assign load         = terminal && !illegal;
   assign park         = terminal && illegal;
   assign tick_o       = load && !rst_i;
   assign zero_ratio_o = park && !rst_i;
endmodule

// File: rtl/divn_checker.sv
module divn_checker #(
   parameter int RATIO_W = 8
) (
   input logic               clk_i,
   input logic               rst_i,
   input logic [RATIO_W-1:0] ratio_i,
   input logic               tick_o,
   input logic               zero_ratio_o
);
   logic [RATIO_W:0]   gap;
   logic [RATIO_W-1:0] rat;
   logic               armed;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         gap <= '0; rat <= '0; armed <= 1'b0;
      end else if (tick_o) begin
         gap <= 1; rat <= ratio_i; armed <= 1'b1;
      end else if (zero_ratio_o) begin
         armed <= 1'b0;
      end else if (gap != '1) begin
         gap <= gap + 1'b1;
      end
   end

   p_excl_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      !(tick_o && zero_ratio_o));
   p_after_reset_r1: assert property (@(posedge clk_i) disable iff (rst_i)
      $past(rst_i) |-> (tick_o || zero_ratio_o));
   p_every_cycle_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (tick_o && ratio_i == 1) |=> (tick_o || zero_ratio_o));
   p_single_wide_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (tick_o && ratio_i > 1) |=> (!tick_o && !zero_ratio_o));
   p_period_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (tick_o && armed) |-> (gap == {1'b0, rat}));
   p_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      (zero_ratio_o && ratio_i == 0) |=> (tick_o || zero_ratio_o));
endmodule

bind prog_freq_divider divn_checker #(.RATIO_W(RATIO_W)) u_divn_chk (
   .clk_i       (clk_i),
   .rst_i       (rst_i),
   .ratio_i     (ratio_i),
   .tick_o      (tick_o),
   .zero_ratio_o(zero_ratio_o)
);

// File: tb/prog_freq_divider_test.sv
`timescale 1ns/1ps
module prog_freq_divider_test;
   logic       clk = 1'b0;
   logic       rst;
   logic [7:0] ratio;
   logic       tick, zr;
   int         checks = 0;
   int         errors = 0;
   int         model_cnt;
   string      tag;
   bit         done = 0;

   always #2.5 clk = ~clk;

   prog_freq_divider uut (
      .clk_i(clk), .rst_i(rst), .ratio_i(ratio),
      .tick_o(tick), .zero_ratio_o(zr)
   );

   // behavioural reference: remaining cycles until next tick
   always @(posedge clk) begin
      if (rst) model_cnt = 0;
      else if (model_cnt == 0) begin
         if (ratio != 0) model_cnt = ratio - 1;
      end else model_cnt = model_cnt - 1;
   end

   task automatic compare();
      bit exp_t, exp_z;
      exp_t = !rst && model_cnt == 0 && ratio != 0;
      exp_z = !rst && model_cnt == 0 && ratio == 0;
      checks++;
      if (tick !== exp_t || zr !== exp_z) begin
         errors++;
         $display("FAIL %s ratio=%0d tick/zero actual=%b%b expected=%b%b",
                  tag, ratio, tick, zr, exp_t, exp_z);
      end
      checks++;
      if (tick === 1'b1 && zr === 1'b1) begin
         errors++;
         $display("FAIL R8 both high actual=11 expected=not 11");
      end
   endtask

   task automatic step(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); compare();
         @(posedge clk); #1;
      end
   endtask

   task automatic wait_tick();
      int guard = 0;
      while (tick !== 1'b1 && guard < 600) begin step(1); guard++; end
   endtask

   // measure spacing between two ticks, named check
   task automatic period(int n, string t);
      int gap = 0;
      tag = t; ratio = n[7:0];
      wait_tick(); step(1);
      while (tick !== 1'b1 && gap < 600) begin step(1); gap++; end
      checks++;
      if (gap + 1 != n) begin
         errors++;
         $display("FAIL %s period actual=%0d expected=%0d", t, gap + 1, n);
      end
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst = 1'b1; ratio = 8'd4; tag = "R1";
      @(posedge clk); #1;
      step(3);                 // R1 outputs low during reset
      rst = 1'b0;
      step(1);                 // R1 tick in first cycle after release
      step(10);
      period(1, "R3"); step(8);
      period(2, "R2");
      period(5, "R2");
      period(255, "R4");
      period(16, "R7");
      period(17, "R7");
      period(32, "R7");
      period(200, "R7");
      // R5: change mid-period, current period keeps its length
      tag = "R5"; ratio = 8'd10;
      wait_tick(); step(3);
      ratio = 8'd3; step(7);   // next tick must still be 10 after the last
      step(12);
      // R6: park with zero ratio, then resume
      tag = "R6"; ratio = 8'd6;
      wait_tick(); step(1);
      ratio = 8'd0; step(15);
      ratio = 8'd7; step(20);
      // R6: zero applied during reset release
      rst = 1'b1; ratio = 8'd0; tag = "R1"; step(2);
      rst = 1'b0; tag = "R6"; step(5);
      ratio = 8'd1; step(4);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule